// File: doc/BRIEF.md
# Dual-Set Gamut Remap Matrix

This block applies a three-by-four colour matrix to a stream of RGB pixels. Every output channel is the weighted sum of the three input channels plus an additive offset. The result is rounded to the nearest integer and clamped to the pixel range. Two complete coefficient sets are held side by side. Software loads one of them while the other is in use, and switches between them without tearing a frame.

The host writes 32-bit words. Each word carries two 16-bit coefficients, six words per set. A pending mode selects bypass, set A or set B. The pending mode becomes the current mode only on a frame-start pulse. The current mode is visible both on a port and through a read-only status word. Software reads the status word, loads the idle set, programs the pending mode and waits for the next frame.

The pixel path has a fixed latency of three clock cycles in every mode. A valid flag travels alongside the data.

Top module: `gamut_matrix_top`

## Requirements
- R1: After reset, `pix_valid_o` is 0, the current mode is 0, the pending mode is 0 and every coefficient word reads back as 0.
- R2: A write to address 0..5 loads a word of set A, and a write to address 8..13 loads the same word of set B. Word p holds coefficient 2p in bits [15:0] and coefficient 2p+1 in bits [31:16]. Coefficient k sits in row k/4 and column k%4. A read returns the written word.
- R3: Bits [1:0] of address 16 hold the pending mode and read back as written. Address 17 returns the current mode in bits [1:0]. Writes to address 17 have no effect on any state.
- R4: The current mode takes the pending mode's value on the clock edge that samples `frame_start` high, and holds it otherwise.
- R5: In mode 0 and mode 3, each output channel equals its input channel.
- R6: Mode 1 uses set A and mode 2 uses set B. Output row n is clamp(round((Cn0*R + Cn1*G + Cn2*B) / 4096) + Cn3). Cn0..Cn2 are signed 16-bit values with 12 fraction bits. Cn3 is a signed integer offset in pixel units. Row 0 drives R, row 1 drives G and row 2 drives B.
- R7: Rounding adds one half and takes the floor, so an exact half rounds upward.
- R8: Results below 0 give 0, and results above 4095 give 4095.
- R9: `pix_valid_o` and the data appear exactly three cycles after the inputs are sampled, in every mode.
- R10: A pixel uses the current mode in force on the edge that samples it. A `frame_start` on that same edge affects only later pixels.
- R11: Writes to addresses outside 0..5, 8..13 and 16 change nothing, and such addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Host write strobe |
| cfg_wr_addr | input | 5 | Host write word address |
| cfg_wr_data | input | 32 | Host write data |
| cfg_rd_addr | input | 5 | Host read word address |
| cfg_rd_data | output | 32 | Host read data (combinational) |
| frame_start | input | 1 | Frame boundary pulse; loads the current mode |
| cur_mode_o | output | 2 | Mode in force |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | 12 | Input red |
| pix_g_i | input | 12 | Input green |
| pix_b_i | input | 12 | Input blue |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_r_o | output | 12 | Output red |
| pix_g_o | output | 12 | Output green |
| pix_b_o | output | 12 | Output blue |

## Verification
The hardest case is a valid pixel sampled on the same edge as `frame_start` while the pending mode differs from the current one. That pixel must still see the old set. The stimulus reaches this case by programming a new pending mode in the middle of a pixel stream and then raising `frame_start` together with a valid pixel. The stream continues under the new set right after. Rounding on exact halves and clamping at both ends are reached with directed coefficient sets: half and quarter weights on small pixel values, and offsets or gains far outside the pixel range.

// File: rtl/gm_pkg.sv
package gm_pkg;
   // mode encoding shared by the register file and the datapath
   typedef enum logic [1:0] {
      MODE_PASS     = 2'd0,
      MODE_SET_A    = 2'd1,
      MODE_SET_B    = 2'd2,
      MODE_PASS_ALT = 2'd3
   } gm_mode_e;

   localparam int unsigned ROWS     = 3;
   localparam int unsigned COLS     = 4;
   localparam int unsigned NUM_COEF = ROWS * COLS;
   localparam int unsigned PAIRS    = NUM_COEF / 2;
endpackage

// File: rtl/gm_regfile.sv
module gm_regfile
   import gm_pkg::*;
#(
   parameter int unsigned COEF_W     = 16,
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned SET_B_BASE = 8,
   parameter int unsigned CTRL_ADDR  = 16,
   parameter int unsigned STAT_ADDR  = 17
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [2*COEF_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [2*COEF_W-1:0]          rd_data,
   input  logic                         frame_start,
   output logic [1:0]                   cur_mode_o,
   output logic [NUM_COEF*COEF_W-1:0]   coef_a_o,
   output logic [NUM_COEF*COEF_W-1:0]   coef_b_o
);
   localparam int unsigned DATA_W = 2 * COEF_W;

   if (SET_B_BASE < PAIRS) begin : g_bad_base
      $error("set B window overlaps set A");
   end
   if (STAT_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("control words do not fit the address width");
   end
   if (CTRL_ADDR == STAT_ADDR) begin : g_bad_ctrl
      $error("control and status share an address");
   end

   logic [1:0] pend_q;
   logic [1:0] cur_q;

   // two banks of coefficient words, one register per word
   for (genvar s = 0; s < 2; s++) begin : g_set
      for (genvar p = 0; p < PAIRS; p++) begin : g_word
         localparam int unsigned WADDR = s * SET_B_BASE + p;
         logic [DATA_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(WADDR))
               word_q <= wr_data;
         end
         if (s == 0) begin : g_a
            assign coef_a_o[p*DATA_W +: DATA_W] = word_q;
         end else begin : g_b
            assign coef_b_o[p*DATA_W +: DATA_W] = word_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 2'd0;
         cur_q  <= 2'd0;
      end else begin
         if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR))
            pend_q <= wr_data[1:0];
         if (frame_start)
            cur_q <= pend_q;
      end
   end

   assign cur_mode_o = cur_q;

   always_comb begin
      rd_data = '0;
      for (int p = 0; p < int'(PAIRS); p++) begin
         if (rd_addr == ADDR_W'(p))
            rd_data = coef_a_o[p*DATA_W +: DATA_W];
         if (rd_addr == ADDR_W'(int'(SET_B_BASE) + p))
            rd_data = coef_b_o[p*DATA_W +: DATA_W];
      end
      if (rd_addr == ADDR_W'(CTRL_ADDR))
         rd_data = {{(DATA_W-2){1'b0}}, pend_q};
      if (rd_addr == ADDR_W'(STAT_ADDR))
         rd_data = {{(DATA_W-2){1'b0}}, cur_q};
   end

   // R4: current mode moves only on a frame boundary, and then to the pending value
   a_r4_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(cur_q));
   a_r4_load_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (cur_q == $past(pend_q)));
endmodule

// File: rtl/gm_mac_row.sv
module gm_mac_row #(
   parameter int unsigned PIX_W  = 12,
   parameter int unsigned COEF_W = 16,
   parameter int unsigned FRAC_W = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  byp_i,
   input  logic [PIX_W-1:0]      r_i,
   input  logic [PIX_W-1:0]      g_i,
   input  logic [PIX_W-1:0]      b_i,
   input  logic [PIX_W-1:0]      pass_i,
   input  logic [4*COEF_W-1:0]   coef_i,
   output logic [PIX_W-1:0]      pix_o
);
   localparam int unsigned PROD_W = PIX_W + 1 + COEF_W;
   localparam int unsigned ACC_W  = PROD_W + 2;
   localparam int unsigned SC_W   = ACC_W - FRAC_W;
   localparam int unsigned PIX_MAX = (1 << PIX_W) - 1;
   localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1 << (FRAC_W - 1));
   localparam logic signed [SC_W-1:0]  MAX_S = SC_W'(PIX_MAX);

   if (FRAC_W == 0 || FRAC_W >= COEF_W) begin : g_bad_frac
      $error("fraction width must lie inside the coefficient");
   end
   if (ACC_W < COEF_W + FRAC_W + 1) begin : g_bad_acc
      $error("accumulator too narrow for the scaled offset");
   end

   logic [PIX_W-1:0]         chan [3];
   logic signed [PROD_W-1:0] prod_d [3];
   logic signed [PROD_W-1:0] prod_q [3];
   logic signed [COEF_W-1:0] off_q;
   logic                     byp_q;
   logic [PIX_W-1:0]         pass_q;
   logic signed [ACC_W-1:0]  acc;
   logic signed [SC_W-1:0]   scaled;
   logic [PIX_W-1:0]         sat_d;

   always_comb begin
      chan[0] = r_i;
      chan[1] = g_i;
      chan[2] = b_i;
   end

   // stage 2: three products and the offset
   for (genvar c = 0; c < 3; c++) begin : g_mul
      assign prod_d[c] = PROD_W'($signed({1'b0, chan[c]}))
                       * PROD_W'($signed(coef_i[c*COEF_W +: COEF_W]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < 3; c++) prod_q[c] <= '0;
         off_q  <= '0;
         byp_q  <= 1'b0;
         pass_q <= '0;
      end else begin
         for (int c = 0; c < 3; c++) prod_q[c] <= prod_d[c];
         off_q  <= $signed(coef_i[3*COEF_W +: COEF_W]);
         byp_q  <= byp_i;
         pass_q <= pass_i;
      end
   end

   // stage 3: sum, round half up, saturate
   always_comb begin
      acc = ACC_W'(prod_q[0]) + ACC_W'(prod_q[1]) + ACC_W'(prod_q[2])
          + (ACC_W'(off_q) <<< FRAC_W) + HALF;
      scaled = SC_W'(acc >>> FRAC_W);
      if (scaled < 0)
         sat_d = '0;
      else if (scaled > MAX_S)
         sat_d = PIX_W'(PIX_MAX);
      else
         sat_d = scaled[PIX_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pix_o <= '0;
      else
         pix_o <= byp_q ? pass_q : sat_d;
   end

   // R5: a bypassed sample leaves unchanged two edges later
   a_r5_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
      byp_i |=> ##1 (pix_o == $past(pass_i, 2)));
   // R8: saturation at both ends of the range
   a_r8_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp_q && scaled > MAX_S) |=> (pix_o == PIX_W'(PIX_MAX)));
   a_r8_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp_q && scaled < 0) |=> (pix_o == '0));
endmodule

// File: rtl/gamut_matrix_top.sv
module gamut_matrix_top
   import gm_pkg::*;
#(
   parameter int unsigned PIX_W      = 12,
   parameter int unsigned COEF_W     = 16,
   parameter int unsigned FRAC_W     = 12,
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned SET_B_BASE = 8,
   parameter int unsigned CTRL_ADDR  = 16,
   parameter int unsigned STAT_ADDR  = 17
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr_en,
   input  logic [ADDR_W-1:0]     cfg_wr_addr,
   input  logic [2*COEF_W-1:0]   cfg_wr_data,
   input  logic [ADDR_W-1:0]     cfg_rd_addr,
   output logic [2*COEF_W-1:0]   cfg_rd_data,
   input  logic                  frame_start,
   output logic [1:0]            cur_mode_o,
   input  logic                  pix_valid_i,
   input  logic [PIX_W-1:0]      pix_r_i,
   input  logic [PIX_W-1:0]      pix_g_i,
   input  logic [PIX_W-1:0]      pix_b_i,
   output logic                  pix_valid_o,
   output logic [PIX_W-1:0]      pix_r_o,
   output logic [PIX_W-1:0]      pix_g_o,
   output logic [PIX_W-1:0]      pix_b_o
);
   localparam int unsigned SET_W = NUM_COEF * COEF_W;
   localparam int unsigned ROW_W = COLS * COEF_W;

   logic [SET_W-1:0] coef_a;
   logic [SET_W-1:0] coef_b;
   logic [SET_W-1:0] coef_sel;
   logic [PIX_W-1:0] s1_pix [ROWS];
   logic [PIX_W-1:0] out_pix [ROWS];
   logic             s1_valid, s2_valid, s3_valid;
   logic             s1_byp, s1_selb;

   gm_regfile #(
      .COEF_W(COEF_W), .ADDR_W(ADDR_W), .SET_B_BASE(SET_B_BASE),
      .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
      .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
      .frame_start(frame_start), .cur_mode_o(cur_mode_o),
      .coef_a_o(coef_a), .coef_b_o(coef_b)
   );

   // stage 1: capture pixel and the mode in force on this edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < int'(ROWS); c++) s1_pix[c] <= '0;
         s1_valid <= 1'b0;
         s1_byp   <= 1'b1;
         s1_selb  <= 1'b0;
      end else begin
         s1_pix[0] <= pix_r_i;
         s1_pix[1] <= pix_g_i;
         s1_pix[2] <= pix_b_i;
         s1_valid  <= pix_valid_i;
         s1_byp    <= (cur_mode_o == MODE_PASS) || (cur_mode_o == MODE_PASS_ALT);
         s1_selb   <= (cur_mode_o == MODE_SET_B);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s3_valid <= 1'b0;
      end else begin
         s2_valid <= s1_valid;
         s3_valid <= s2_valid;
      end
   end

   assign coef_sel = s1_selb ? coef_b : coef_a;

   for (genvar n = 0; n < ROWS; n++) begin : g_row
      gm_mac_row #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_row (
         .clk(clk), .rst_n(rst_n), .byp_i(s1_byp),
         .r_i(s1_pix[0]), .g_i(s1_pix[1]), .b_i(s1_pix[2]),
         .pass_i(s1_pix[n]),
         .coef_i(coef_sel[n*ROW_W +: ROW_W]),
         .pix_o(out_pix[n])
      );
   end

   assign pix_valid_o = s3_valid;
   assign pix_r_o     = out_pix[0];
   assign pix_g_o     = out_pix[1];
   assign pix_b_o     = out_pix[2];

   // R9: valid emerges three edges after it is sampled
   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid_i |=> ##2 pix_valid_o);
   a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid_i |=> ##2 !pix_valid_o);
endmodule

// File: tb/tb_gamut_matrix_top.sv
`timescale 1ns/1ps
module tb_gamut_matrix_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [4:0]  cfg_wr_addr = '0;
   logic [31:0] cfg_wr_data = '0;
   logic [4:0]  cfg_rd_addr = '0;
   logic [31:0] cfg_rd_data;
   logic        frame_start = 1'b0;
   logic [1:0]  cur_mode_o;
   logic        pix_valid_i = 1'b0;
   logic [11:0] pix_r_i = '0, pix_g_i = '0, pix_b_i = '0;
   logic        pix_valid_o;
   logic [11:0] pix_r_o, pix_g_o, pix_b_o;

   gamut_matrix_top dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
      .frame_start(frame_start), .cur_mode_o(cur_mode_o),
      .pix_valid_i(pix_valid_i), .pix_r_i(pix_r_i), .pix_g_i(pix_g_i), .pix_b_i(pix_b_i),
      .pix_valid_o(pix_valid_o), .pix_r_o(pix_r_o), .pix_g_o(pix_g_o), .pix_b_o(pix_b_o)
   );

   always #2 clk = ~clk;

   typedef struct {
      bit    v;
      int    r, g, b;
      string tag;
   } exp_t;

   exp_t  eq[$];
   int    cset [2][12];
   int    model_pend = 0;
   int    model_cur  = 0;
   string tag = "R5";
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   task automatic chk(bit ok, string req, string what, longint act, longint ex);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, ex);
      end
   endtask

   function automatic int calc(int m, int row, int r, int g, int b, int pass);
      longint acc;
      longint q;
      int s;
      if (m == 0 || m == 3) return pass;
      s = (m == 2) ? 1 : 0;
      acc = longint'(cset[s][row*4]) * r + longint'(cset[s][row*4+1]) * g
          + longint'(cset[s][row*4+2]) * b + longint'(cset[s][row*4+3]) * 4096 + 2048;
      q = acc >>> 12;
      if (q < 0) return 0;
      if (q > 4095) return 4095;
      return int'(q);
   endfunction

   function automatic logic [31:0] word_of(int s, int p);
      return {16'(cset[s][2*p+1]), 16'(cset[s][2*p])};
   endfunction

   task automatic cyc(bit v, int r, int g, int b, bit fs,
                      bit we = 1'b0, int a = 0, logic [31:0] d = '0);
      exp_t e;
      @(negedge clk);
      chk(cur_mode_o == 2'(model_cur), "R4", "current mode port", cur_mode_o, model_cur);
      if (eq.size() == 3) begin
         e = eq.pop_front();
         chk(pix_valid_o == e.v, "R9", "output valid", pix_valid_o, e.v);
         if (e.v) begin
            chk(int'(pix_r_o) == e.r, e.tag, "red", pix_r_o, e.r);
            chk(int'(pix_g_o) == e.g, e.tag, "green", pix_g_o, e.g);
            chk(int'(pix_b_o) == e.b, e.tag, "blue", pix_b_o, e.b);
         end
      end
      pix_valid_i = v;
      pix_r_i = 12'(r); pix_g_i = 12'(g); pix_b_i = 12'(b);
      frame_start = fs;
      cfg_wr_en = we; cfg_wr_addr = 5'(a); cfg_wr_data = d;
      e.v = v; e.tag = tag;
      e.r = calc(model_cur, 0, r, g, b, r);
      e.g = calc(model_cur, 1, r, g, b, g);
      e.b = calc(model_cur, 2, r, g, b, b);
      eq.push_back(e);
      if (fs) model_cur = model_pend;
      if (we && a == 16) model_pend = int'(d[1:0]);
   endtask

   task automatic wr(int a, logic [31:0] d);
      cyc(1'b0, 0, 0, 0, 1'b0, 1'b1, a, d);
   endtask

   task automatic rd(int a, logic [31:0] ex, string req);
      cfg_rd_addr = 5'(a);
      #1;
      chk(cfg_rd_data == ex, req, $sformatf("read addr %0d", a), cfg_rd_data, ex);
   endtask

   task automatic load_set(int s);
      for (int p = 0; p < 6; p++) wr(s * 8 + p, word_of(s, p));
   endtask

   task automatic rand_set(int s);
      for (int k = 0; k < 12; k++)
         if (k % 4 == 3) cset[s][k] = int'($urandom_range(400)) - 200;
         else            cset[s][k] = int'($urandom_range(6144)) - 2048;
   endtask

   task automatic stream(int n);
      for (int i = 0; i < n; i++)
         cyc(($urandom_range(7) != 0), int'($urandom_range(4095)),
             int'($urandom_range(4095)), int'($urandom_range(4095)), 1'b0);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 0, 1'b0);
   endtask

   initial begin
      void'($urandom(32'd2718));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      #1;
      chk(pix_valid_o == 1'b0, "R1", "valid after reset", pix_valid_o, 0);
      chk(cur_mode_o == 2'd0, "R1", "mode after reset", cur_mode_o, 0);
      rd(0, 32'd0, "R1");
      rd(13, 32'd0, "R1");
      rd(16, 32'd0, "R1");

      // R2: both sets, packed pairs
      rand_set(0); rand_set(1);
      load_set(0); load_set(1);
      idle(1);
      for (int p = 0; p < 6; p++) begin
         rd(p, word_of(0, p), "R2");
         rd(8 + p, word_of(1, p), "R2");
      end
      // R11: unmapped addresses
      wr(6, 32'hDEAD_BEEF);
      wr(20, 32'h1234_5678);
      idle(1);
      rd(6, 32'd0, "R11");
      rd(20, 32'd0, "R11");
      rd(5, word_of(0, 5), "R11");
      rd(8, word_of(1, 0), "R11");

      // R5: bypass mode 0
      tag = "R5";
      stream(20);

      // R3 / R4: pending mode does not act before a frame boundary
      wr(16, 32'd1);
      idle(1);
      rd(16, 32'd1, "R3");
      rd(17, 32'd0, "R3");
      tag = "R4";
      stream(6);
      cyc(1'b0, 0, 0, 0, 1'b1);
      idle(1);
      rd(17, 32'd1, "R3");

      // R6: set A with extremes
      tag = "R6";
      stream(30);
      cyc(1'b1, 0, 0, 0, 1'b0);
      cyc(1'b1, 4095, 4095, 4095, 1'b0);
      cyc(1'b1, 4095, 0, 4095, 1'b0);

      // R10: frame boundary coinciding with a valid pixel
      cyc(1'b1, 100, 200, 300, 1'b0, 1'b1, 16, 32'd2);
      tag = "R10";
      cyc(1'b1, 3000, 1500, 700, 1'b1);
      tag = "R6";
      stream(30);

      // R5: mode 3 behaves as bypass
      wr(16, 32'd3);
      cyc(1'b0, 0, 0, 0, 1'b1);
      tag = "R5";
      stream(12);

      // R3: status word is read only
      wr(17, 32'd1);
      idle(2);
      rd(17, 32'd3, "R3");
      rd(16, 32'd3, "R3");

      // R7: rounding of exact halves
      for (int k = 0; k < 12; k++) cset[0][k] = 0;
      cset[0][0]  = 16'sh0800;      // +0.5 on R for row 0
      cset[0][5]  = -2048;          // -0.5 on G for row 1
      cset[0][7]  = 1;              // +1 offset for row 1
      cset[0][10] = 16'sh0400;      // +0.25 on B for row 2
      load_set(0);
      wr(16, 32'd1);
      cyc(1'b0, 0, 0, 0, 1'b1);
      tag = "R7";
      cyc(1'b1, 1, 1, 2, 1'b0);
      cyc(1'b1, 3, 3, 6, 1'b0);
      cyc(1'b1, 2, 2, 10, 1'b0);
      cyc(1'b1, 5, 4, 14, 1'b0);
      idle(3);
      rd(17, 32'd1, "R3");

      // R8: saturation, loaded into the idle set B
      for (int k = 0; k < 12; k++) cset[1][k] = 0;
      cset[1][3]  = 5000;
      cset[1][7]  = -5000;
      cset[1][8]  = 32767;
      load_set(1);
      wr(16, 32'd2);
      cyc(1'b0, 0, 0, 0, 1'b1);
      tag = "R8";
      cyc(1'b1, 4095, 4095, 4095, 1'b0);
      cyc(1'b1, 0, 0, 0, 1'b0);
      stream(10);

      // R6: random set B after random reload
      rand_set(1);
      wr(16, 32'd1);
      cyc(1'b0, 0, 0, 0, 1'b1);
      load_set(1);
      wr(16, 32'd2);
      cyc(1'b0, 0, 0, 0, 1'b1);
      tag = "R6";
      stream(40);
      idle(4);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule